// File: doc/BRIEF.md
# Channel Volume Envelope

This block produces the 4-bit amplitude of a sound channel and moves it by one step at a programmable interval. Software writes one configuration byte that holds a starting level, a direction flag and a 3-bit step interval. A trigger strobe restarts the envelope from the starting level. An external slow pulse, typically near 64 Hz, advances the envelope. Each pulse counts down the interval. When the count runs out, the level moves one step up or down and the count starts again.

The same configuration byte also decides whether the channel's output converter is powered. The converter is on when any of the upper five bits is set. A write that clears all five bits raises a one-cycle shutdown event, which the surrounding channel logic uses to stop the channel.

Top module: `vol_envelope`

## Requirements
- R1: After reset the level output is 0, the configuration read-back is 0, the converter-enable flag is 0 and the shutdown event is 0.
- R2: The configuration read-back equals the last byte written, from the cycle after the write. Field positions: bits 7:4 are the starting level, bit 3 is the direction (1 = up, 0 = down), and bits 2:0 are the step interval.
- R3: The converter-enable flag is 1 exactly when any of configuration bits 7:3 is 1. In the cycle after a write whose bits 7:3 are all 0, the shutdown event is 1 for exactly one cycle.
- R4: A trigger loads the level with the starting level. The new level is visible in the cycle after the trigger.
- R5: While the step interval is 0, envelope pulses leave the level unchanged.
- R6: With a nonzero interval P, the level changes on the P-th envelope pulse after a trigger and then on every P-th pulse after that. For example, start 7 with P = 1 gives 6 after one pulse when going down, and 8 when going up.
- R7: The level saturates: it stays at 15 when going up and stays at 0 when going down. It never wraps.
- R8: When a trigger and an envelope pulse occur in the same cycle, the trigger wins and that pulse is ignored. The countdown restarts from the full interval.
- R9: A configuration write does not change the current level. A new starting level takes effect only at the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_rdata | output | 8 | Stored configuration byte |
| trig | input | 1 | Restart strobe |
| env_tick | input | 1 | Envelope advance pulse |
| volume | output | 4 | Current level |
| dac_en | output | 1 | Output converter powered |
| dac_off_evt | output | 1 | One-cycle pulse: the channel must stop |

## Verification
A restart and an envelope pulse can land in the same clock cycle, and so can a configuration write and a running envelope. The bench drives a trigger together with a pulse and expects two things: the level equals the starting level, not one step past it, and exactly one full interval is needed before the next step. It also rewrites the configuration byte between steps and expects the level to hold until a new trigger.

// File: rtl/vol_env_pkg.sv
package vol_env_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } env_dir_e;

   // one saturating step of a level of width w (w <= 16)
   function automatic logic [15:0] sat_step(input logic [15:0] lvl,
                                            input logic [15:0] top,
                                            input env_dir_e    dir);
      logic [15:0] r;
      if (dir == DIR_UP) r = (lvl >= top) ? top : lvl + 16'd1;
      else               r = (lvl == 16'd0) ? 16'd0 : lvl - 16'd1;
      return r;
   endfunction

endpackage

// File: rtl/env_cfg_reg.sv
module env_cfg_reg #(
   parameter int VOL_W = 4,
   parameter int PER_W = 3,
   localparam int CFG_W = VOL_W + 1 + PER_W,
   localparam int HI_W  = CFG_W - PER_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q,
   output logic [VOL_W-1:0] init_vol,
   output vol_env_pkg::env_dir_e dir,
   output logic [PER_W-1:0] period,
   output logic             dac_en,
   output logic             dac_off_evt
);
   logic [HI_W-1:0] hi_bits;
   logic            off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         off_q <= 1'b0;
      end else begin
         if (we) cfg_q <= wdata;
         off_q <= we && (wdata[CFG_W-1:PER_W] == '0);
      end
   end

   for (genvar g = 0; g < HI_W; g++) begin : g_hi
      assign hi_bits[g] = cfg_q[PER_W+g];
   end

   assign dac_en      = |hi_bits;
   assign dac_off_evt = off_q;
   assign init_vol    = cfg_q[CFG_W-1 -: VOL_W];
   assign dir         = vol_env_pkg::env_dir_e'(cfg_q[PER_W]);
   assign period      = cfg_q[PER_W-1:0];

   // R3: a shutdown pulse always comes with the converter off
   a_r3_off_means_dac_low: assert property (@(posedge clk) disable iff (!rst_n)
      dac_off_evt |-> !dac_en);
   // R3: the pulse lasts one cycle unless written again
   a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_off_evt && !we) |=> !dac_off_evt);
endmodule

// File: rtl/env_timer.sv
module env_timer #(
   parameter int PER_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   output logic             step
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] cnt_dec;
   logic             active;

   assign active  = (period != '0);
   assign cnt_dec = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
   assign step    = tick && !trig && active && (cnt_dec == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (trig)
         cnt_q <= period;
      else if (tick && active)
         cnt_q <= (cnt_dec == '0) ? period : cnt_dec;
   end

   // R6: after a step the countdown restarts from the full interval
   a_r6_reload_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt_q == $past(period)));
   // R8: a trigger suppresses any step in its cycle
   a_r8_trig_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> !step);
endmodule

// File: rtl/env_level.sv
module env_level #(
   parameter int VOL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             step,
   input  logic [VOL_W-1:0] init_vol,
   input  vol_env_pkg::env_dir_e dir,
   output logic [VOL_W-1:0] vol_q
);
   localparam logic [VOL_W-1:0] VMAX = '1;
   logic [15:0] nxt;

   assign nxt = vol_env_pkg::sat_step(16'(vol_q), 16'(VMAX), dir);

   always_ff @(posedge clk) begin
      if (!rst_n)          vol_q <= '0;
      else if (trig)       vol_q <= init_vol;
      else if (step)       vol_q <= nxt[VOL_W-1:0];
   end

   // R4: a trigger loads the starting level
   a_r4_trig_load: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (vol_q == $past(init_vol)));
   // R7: no wrap at either end
   a_r7_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_q == VMAX && !trig) |=> (vol_q != '0));
   a_r7_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_q == '0 && !trig) |=> (vol_q != VMAX));
   // R9: without trigger or step the level holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && !step) |=> $stable(vol_q));
endmodule

// File: rtl/vol_envelope.sv
module vol_envelope #(
   parameter int VOL_W = 4,
   parameter int PER_W = 3,
   localparam int CFG_W = VOL_W + 1 + PER_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             trig,
   input  logic             env_tick,
   output logic [VOL_W-1:0] volume,
   output logic             dac_en,
   output logic             dac_off_evt
);
   if (VOL_W < 1 || VOL_W > 16 || PER_W < 1 || PER_W > 16) begin : g_bad_param
      initial $fatal(1, "vol_envelope: VOL_W and PER_W must be 1..16");
   end

   logic [VOL_W-1:0]      init_vol;
   logic [PER_W-1:0]      period;
   vol_env_pkg::env_dir_e dir;
   logic                  step;

   env_cfg_reg #(.VOL_W(VOL_W), .PER_W(PER_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .cfg_q(cfg_rdata), .init_vol(init_vol), .dir(dir), .period(period),
      .dac_en(dac_en), .dac_off_evt(dac_off_evt));

   env_timer #(.PER_W(PER_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .trig(trig), .tick(env_tick),
      .period(period), .step(step));

   env_level #(.VOL_W(VOL_W)) u_level (
      .clk(clk), .rst_n(rst_n), .trig(trig), .step(step),
      .init_vol(init_vol), .dir(dir), .vol_q(volume));

   // R5: a zero interval freezes the level between triggers
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 && !trig) |=> $stable(volume));
   // R2: a write is visible in the next cycle
   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/vol_envelope_bench.sv
module vol_envelope_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       trig = 1'b0;
   logic       env_tick = 1'b0;
   logic [3:0] volume;
   logic       dac_en;
   logic       dac_off_evt;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      string tag;
      int    sel;   // 0 volume, 1 readback, 2 dac_en, 3 dac_off_evt
      int    val;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   vol_envelope u_vol_envelope (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .trig(trig), .env_tick(env_tick),
      .volume(volume), .dac_en(dac_en), .dac_off_evt(dac_off_evt));

   // monitor: compare queued expectations against outputs away from the edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         int act;
         e = q.pop_front();
         case (e.sel)
            0: act = int'(volume);
            1: act = int'(cfg_rdata);
            2: act = int'(dac_en);
            default: act = int'(dac_off_evt);
         endcase
         n_run++;
         if (act != e.val) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%0d expected=%0d", e.tag, e.sel, act, e.val);
         end
      end
   end

   task automatic cyc(input bit we, input logic [7:0] wd, input bit tr, input bit tk);
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; trig = tr; env_tick = tk;
      @(posedge clk);
      #1;
      cfg_we = 1'b0; trig = 1'b0; env_tick = 1'b0;
   endtask

   task automatic expect_v(input string tag, input int sel, input int val);
      exp_t e;
      e.tag = tag; e.sel = sel; e.val = val;
      q.push_back(e);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_v("R1", 0, 0); expect_v("R1", 1, 0);
      expect_v("R1", 2, 0); expect_v("R1", 3, 0);
      cyc(0, 0, 0, 0);

      // R2/R3 write, R4 trigger, R6 example down
      cyc(1, 8'h71, 0, 0);
      expect_v("R2", 1, 8'h71); expect_v("R3", 2, 1); expect_v("R3", 3, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 7);
      cyc(0, 0, 0, 1); expect_v("R6", 0, 6);

      // R6 example up
      cyc(1, 8'h79, 0, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 7);
      cyc(0, 0, 0, 1); expect_v("R6", 0, 8);

      // R6 interval 3 down from 10
      cyc(1, 8'hA3, 0, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 10);
      cyc(0, 0, 0, 1); expect_v("R6", 0, 10);
      cyc(0, 0, 0, 1); expect_v("R6", 0, 10);
      cyc(0, 0, 0, 1); expect_v("R6", 0, 9);
      cyc(0, 0, 0, 1); cyc(0, 0, 0, 1); expect_v("R6", 0, 9);
      cyc(0, 0, 0, 1); expect_v("R6", 0, 8);

      // R7 saturation up
      cyc(1, 8'hE9, 0, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 14);
      cyc(0, 0, 0, 1); expect_v("R7", 0, 15);
      cyc(0, 0, 0, 1); expect_v("R7", 0, 15);
      // R7 saturation down
      cyc(1, 8'h11, 0, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 1);
      cyc(0, 0, 0, 1); expect_v("R7", 0, 0);
      cyc(0, 0, 0, 1); expect_v("R7", 0, 0);

      // R5 zero interval
      cyc(1, 8'h50, 0, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 5);
      cyc(0, 0, 0, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
      expect_v("R5", 0, 5);

      // R9 write does not disturb level
      cyc(1, 8'h71, 0, 0);
      cyc(0, 0, 1, 0); expect_v("R4", 0, 7);
      cyc(1, 8'h32, 0, 0); expect_v("R9", 0, 7); expect_v("R2", 1, 8'h32);
      cyc(0, 0, 1, 0); expect_v("R9", 0, 3);

      // R8 trigger and tick together, interval 2 down from 3
      cyc(0, 0, 0, 1); expect_v("R8", 0, 3);
      cyc(0, 0, 1, 1); expect_v("R8", 0, 3);
      cyc(0, 0, 0, 1); expect_v("R8", 0, 3);
      cyc(0, 0, 0, 1); expect_v("R8", 0, 2);

      // R3 converter control
      cyc(1, 8'h07, 0, 0); expect_v("R3", 2, 0); expect_v("R3", 3, 1);
      expect_v("R9", 0, 2);
      cyc(0, 0, 0, 0); expect_v("R3", 3, 0);
      cyc(1, 8'h08, 0, 0); expect_v("R3", 2, 1); expect_v("R3", 3, 0);
      cyc(1, 8'h00, 0, 0); expect_v("R3", 2, 0); expect_v("R3", 3, 1);
      cyc(0, 0, 0, 0); expect_v("R3", 3, 0);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule